// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Matcher

This block decides which receive slot, if any, takes an incoming CAN frame. A frame header is presented for one cycle as a 29-bit identifier with its extended-format flag (IDE) and its remote-request flag (RTR). The header is compared in parallel against a bank of programmable receive slots. Each slot holds an identifier, an IDE value, an RTR value and an enable. One clock later the block reports whether a slot matched and the index of the winning slot.

Each slot compares the frame through an acceptance mask. Which mask applies depends on three mode inputs. The first selects per-slot masks or shared masks. The second says whether a receive queue occupies the low-numbered slots. The third lets the IDE comparison itself be masked. The masks and slot words are loaded through a plain address/data write port. Frame reception, payload storage and queue pointer handling sit outside this block.

The control is a two-state machine. `ST_IDLE` waits for a frame. Transition *accept* (`frm_valid` high) leads to `ST_RESULT`, in which `res_valid` is high for one cycle. Transition *chain* (`frm_valid` high again) stays in `ST_RESULT`. Transition *drain* (`frm_valid` low) returns to `ST_IDLE`.

Top module: `can_acf_matcher`

## Requirements
- R1: For every identifier bit, a mask bit of 1 requires the frame bit to equal the slot bit, and a mask bit of 0 makes that bit ignored. An 11-bit standard identifier, and its slot value and mask, sit in identifier bits 28:18. Slot words are laid out as bit 31 = IDE, bit 30 = RTR, bit 29 = enable, bits 28:0 = identifier. Mask bits 28:0 cover the identifier.
- R2: With `mask_indiv` = 1, slot n uses individual mask n (write address 32+n), and this includes slots 14 and 15.
- R3: With `mask_indiv` = 0 and the queue off, every slot uses the shared mask (address 64). The exceptions are slot 14, which uses address 65, and slot 15, which uses address 66.
- R4: With `mask_indiv` = 0 and `queue_en` = 1, the queue owns slots 0 to 8*(`queue_size`+1)-1, and these slots use the queue mask (address 67). Slots 14 and 15 keep their dedicated masks only while they lie outside that range.
- R5: With `ext_acc_en` = 0, the frame IDE must equal the slot IDE. With `ext_acc_en` = 1, IDE is compared only when mask bit 31 is set. With an all-zero mask, a slot then accepts both formats. `res_ide` always returns the IDE of the evaluated frame.
- R6: RTR is compared only when mask bit 30 is set.
- R7: Only enabled slots take part in matching. When several enabled slots match, the lowest index wins.
- R8: `res_valid` is high exactly in the cycle after each `frm_valid` cycle, and back-to-back frames give back-to-back results. A frame that matches no slot gives `hit` = 0 and `hit_idx` = 0. While `res_valid` is low, `hit` and `hit_idx` are 0.
- R9: A write takes effect for frames presented in later cycles. A frame presented in the same cycle as a write is judged with the previous contents.
- R10: After reset, all slots are disabled, all masks are zero and all outputs are low, so the first frame misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Write address: 0-31 slots, 32-63 individual masks, 64 shared, 65 slot-14, 66 slot-15, 67 queue mask |
| wr_data | input | 32 | Write data |
| mask_indiv | input | 1 | 1 = per-slot masks, 0 = shared masks |
| queue_en | input | 1 | Receive queue owns the low slots |
| queue_size | input | 2 | Queue occupies 8*(value+1) slots |
| ext_acc_en | input | 1 | IDE comparison governed by mask bit 31 |
| frm_valid | input | 1 | One-cycle frame header strobe |
| frm_id | input | 29 | Frame identifier |
| frm_ide | input | 1 | Frame extended-format flag |
| frm_rtr | input | 1 | Frame remote-request flag |
| res_valid | output | 1 | Result strobe, one cycle after `frm_valid` |
| hit | output | 1 | A slot accepted the frame |
| hit_idx | output | 5 | Winning slot index |
| res_ide | output | 1 | IDE of the evaluated frame |

## Verification
The hardest case to reach from the ports is the hand-over of slots 14 and 15 between their dedicated masks and the queue mask. It shows only when the queue is enabled in shared-mask mode, the queue size crosses slot 14, every lower slot is disabled or fails, and the dedicated masks and the queue mask disagree. The stimulus programs the dedicated masks, the shared mask and the queue mask to differing values. It then steps `queue_size` and the slot enables between frames that carry the same identifier, so a change in the winning index can only come from a change in mask selection. A write placed in the same cycle as a frame checks that the old mask still applies to that frame.

// File: rtl/can_acf_pkg.sv
package can_acf_pkg;

    localparam int ID_W    = 29;
    localparam int WORD_W  = 32;
    localparam int IDE_BIT = 31;
    localparam int RTR_BIT = 30;

    // slot word: ide | rtr | enable | identifier
    typedef struct packed {
        logic            ide;
        logic            rtr;
        logic            en;
        logic [ID_W-1:0] id;
    } slot_word_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } acf_state_e;

endpackage

// File: rtl/can_acf_regs.sv
module can_acf_regs
    import can_acf_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int AW        = 7
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [AW-1:0]                      wr_addr,
    input  logic [WORD_W-1:0]                  wr_data,
    output logic [NUM_SLOTS-1:0][WORD_W-1:0]   slot_q,
    output logic [NUM_SLOTS-1:0][WORD_W-1:0]   imask_q,
    output logic [WORD_W-1:0]                  gmask_q,
    output logic [WORD_W-1:0]                  dmask_a_q,
    output logic [WORD_W-1:0]                  dmask_b_q,
    output logic [WORD_W-1:0]                  qmask_q
);

    localparam int IMASK_BASE = NUM_SLOTS;
    localparam int GMASK_ADDR = 2 * NUM_SLOTS;
    localparam int DMA_ADDR   = GMASK_ADDR + 1;
    localparam int DMB_ADDR   = GMASK_ADDR + 2;
    localparam int QM_ADDR    = GMASK_ADDR + 3;

    genvar g;
    generate
        for (g = 0; g < NUM_SLOTS; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slot_q[g]  <= '0;
                    imask_q[g] <= '0;
                end else if (wr_en) begin
                    if (wr_addr == AW'(g))
                        slot_q[g] <= wr_data;
                    if (wr_addr == AW'(IMASK_BASE + g))
                        imask_q[g] <= wr_data;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gmask_q   <= '0;
            dmask_a_q <= '0;
            dmask_b_q <= '0;
            qmask_q   <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(GMASK_ADDR)) gmask_q   <= wr_data;
            if (wr_addr == AW'(DMA_ADDR))   dmask_a_q <= wr_data;
            if (wr_addr == AW'(DMB_ADDR))   dmask_b_q <= wr_data;
            if (wr_addr == AW'(QM_ADDR))    qmask_q   <= wr_data;
        end
    end

endmodule

// File: rtl/can_acf_mask_sel.sv
module can_acf_mask_sel
    import can_acf_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int QSEG      = 8,
    parameter int DED_A     = 14,
    parameter int DED_B     = 15,
    parameter int QSZ_W     = 2
) (
    input  logic                              mask_indiv,
    input  logic                              queue_en,
    input  logic [QSZ_W-1:0]                  queue_size,
    input  logic [NUM_SLOTS-1:0][WORD_W-1:0]  imask_q,
    input  logic [WORD_W-1:0]                 gmask_q,
    input  logic [WORD_W-1:0]                 dmask_a_q,
    input  logic [WORD_W-1:0]                 dmask_b_q,
    input  logic [WORD_W-1:0]                 qmask_q,
    output logic [NUM_SLOTS-1:0][WORD_W-1:0]  eff_mask
);

    localparam int QL_W = $clog2(NUM_SLOTS) + 2;

    logic [QL_W-1:0] q_len;

    always_comb begin
        q_len = (QL_W'(queue_size) + QL_W'(1)) * QL_W'(QSEG);
    end

    genvar n;
    generate
        for (n = 0; n < NUM_SLOTS; n++) begin : g_sel
            logic in_queue;
            logic [WORD_W-1:0] shared_m;

            assign in_queue = queue_en && (QL_W'(n) < q_len);

            if (n == DED_A) begin : g_ded_a
                assign shared_m = dmask_a_q;
            end else if (n == DED_B) begin : g_ded_b
                assign shared_m = dmask_b_q;
            end else begin : g_plain
                assign shared_m = gmask_q;
            end

            always_comb begin
                if (mask_indiv)
                    eff_mask[n] = imask_q[n];
                else if (in_queue)
                    eff_mask[n] = qmask_q;
                else
                    eff_mask[n] = shared_m;
            end
        end
    endgenerate

endmodule

// File: rtl/can_acf_cmp.sv
module can_acf_cmp
    import can_acf_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int IDX_W     = 5
) (
    input  logic [NUM_SLOTS-1:0][WORD_W-1:0]  slot_q,
    input  logic [NUM_SLOTS-1:0][WORD_W-1:0]  eff_mask,
    input  logic                              ext_acc_en,
    input  logic [ID_W-1:0]                   frm_id,
    input  logic                              frm_ide,
    input  logic                              frm_rtr,
    output logic                              any_hit,
    output logic [IDX_W-1:0]                  win_idx
);

    logic [NUM_SLOTS-1:0] match;

    genvar n;
    generate
        for (n = 0; n < NUM_SLOTS; n++) begin : g_cmp
            slot_word_t sw;
            logic id_ok, ide_ok, rtr_ok;

            assign sw     = slot_word_t'(slot_q[n]);
            assign id_ok  = ((sw.id ^ frm_id) & eff_mask[n][ID_W-1:0]) == '0;
            assign ide_ok = ext_acc_en ? !(eff_mask[n][IDE_BIT] && (sw.ide != frm_ide))
                                       : (sw.ide == frm_ide);
            assign rtr_ok = !(eff_mask[n][RTR_BIT] && (sw.rtr != frm_rtr));
            assign match[n] = sw.en && id_ok && ide_ok && rtr_ok;
        end
    endgenerate

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (match[i]) begin
                any_hit = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/can_acf_matcher.sv
module can_acf_matcher
    import can_acf_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int QSEG      = 8,
    parameter int DED_A     = 14,
    parameter int DED_B     = 15,
    parameter int QSZ_W     = 2,
    parameter int AW        = 7,
    parameter int IDX_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              mask_indiv,
    input  logic              queue_en,
    input  logic [QSZ_W-1:0]  queue_size,
    input  logic              ext_acc_en,
    input  logic              frm_valid,
    input  logic [28:0]       frm_id,
    input  logic              frm_ide,
    input  logic              frm_rtr,
    output logic              res_valid,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic              res_ide
);

    logic [NUM_SLOTS-1:0][WORD_W-1:0] slot_q;
    logic [NUM_SLOTS-1:0][WORD_W-1:0] imask_q;
    logic [NUM_SLOTS-1:0][WORD_W-1:0] eff_mask;
    logic [WORD_W-1:0] gmask_q, dmask_a_q, dmask_b_q, qmask_q;
    logic [NUM_SLOTS-1:0] slot_en;
    logic                 any_hit;
    logic [IDX_W-1:0]     win_idx;

    acf_state_e state_q, state_d;

    genvar n;
    generate
        for (n = 0; n < NUM_SLOTS; n++) begin : g_en
            assign slot_en[n] = slot_q[n][ID_W];
        end
    endgenerate

    can_acf_regs #(
        .NUM_SLOTS (NUM_SLOTS),
        .AW        (AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .slot_q    (slot_q),
        .imask_q   (imask_q),
        .gmask_q   (gmask_q),
        .dmask_a_q (dmask_a_q),
        .dmask_b_q (dmask_b_q),
        .qmask_q   (qmask_q)
    );

    can_acf_mask_sel #(
        .NUM_SLOTS (NUM_SLOTS),
        .QSEG      (QSEG),
        .DED_A     (DED_A),
        .DED_B     (DED_B),
        .QSZ_W     (QSZ_W)
    ) u_msel (
        .mask_indiv (mask_indiv),
        .queue_en   (queue_en),
        .queue_size (queue_size),
        .imask_q    (imask_q),
        .gmask_q    (gmask_q),
        .dmask_a_q  (dmask_a_q),
        .dmask_b_q  (dmask_b_q),
        .qmask_q    (qmask_q),
        .eff_mask   (eff_mask)
    );

    can_acf_cmp #(
        .NUM_SLOTS (NUM_SLOTS),
        .IDX_W     (IDX_W)
    ) u_cmp (
        .slot_q     (slot_q),
        .eff_mask   (eff_mask),
        .ext_acc_en (ext_acc_en),
        .frm_id     (frm_id),
        .frm_ide    (frm_ide),
        .frm_rtr    (frm_rtr),
        .any_hit    (any_hit),
        .win_idx    (win_idx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: accept, chain, drain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = frm_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = frm_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit     <= 1'b0;
            hit_idx <= '0;
            res_ide <= 1'b0;
        end else if (frm_valid) begin
            hit     <= any_hit;
            hit_idx <= any_hit ? win_idx : '0;
            res_ide <= frm_ide;
        end else begin
            hit     <= 1'b0;
            hit_idx <= '0;
            res_ide <= 1'b0;
        end
    end

    assign res_valid = (state_q == ST_RESULT);

endmodule

// File: rtl/can_acf_checker.sv
module can_acf_checker #(
    parameter int NUM_SLOTS = 32,
    parameter int IDX_W     = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frm_valid,
    input logic                 frm_ide,
    input logic                 res_valid,
    input logic                 hit,
    input logic [IDX_W-1:0]     hit_idx,
    input logic                 res_ide,
    input logic [NUM_SLOTS-1:0] slot_en
);

    logic [NUM_SLOTS-1:0] en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= slot_en;
    end

    a_r8_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> res_valid);

    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !res_valid);

    a_r8_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!hit && hit_idx == '0));

    a_r5_ide_carried: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> (res_ide == $past(frm_ide)));

    a_r7_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> en_q[hit_idx]);

endmodule

bind can_acf_matcher can_acf_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_valid (frm_valid),
    .frm_ide   (frm_ide),
    .res_valid (res_valid),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .res_ide   (res_ide),
    .slot_en   (slot_en)
);

// File: tb/tb_can_acf_matcher.sv
module tb_can_acf_matcher;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        mask_indiv = 1'b1;
    logic        queue_en = 1'b0;
    logic [1:0]  queue_size = '0;
    logic        ext_acc_en = 1'b0;
    logic        frm_valid = 1'b0;
    logic [28:0] frm_id = '0;
    logic        frm_ide = 1'b0;
    logic        frm_rtr = 1'b0;
    logic        res_valid, hit, res_ide;
    logic [4:0]  hit_idx;

    always #2 clk = ~clk;

    can_acf_matcher dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mask_indiv(mask_indiv), .queue_en(queue_en), .queue_size(queue_size),
        .ext_acc_en(ext_acc_en), .frm_valid(frm_valid), .frm_id(frm_id),
        .frm_ide(frm_ide), .frm_rtr(frm_rtr), .res_valid(res_valid), .hit(hit),
        .hit_idx(hit_idx), .res_ide(res_ide)
    );

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic       hit;
        logic [4:0] idx;
        logic       ide;
        string      tag;
    } exp_t;

    exp_t sbq[$];

    logic [31:0] sh_slot[32];
    logic [31:0] sh_im[32];
    logic [31:0] sh_g = '0, sh_a = '0, sh_b = '0, sh_q = '0;

    localparam logic [28:0] ID_A  = 29'h08 << 18;
    localparam logic [28:0] ID_B  = 29'h123 << 18;
    localparam logic [28:0] ID_C  = 29'h09 << 18;
    localparam logic [28:0] ID_X  = 29'h4bc0001;
    localparam logic [31:0] STD_M = 32'h1FFC0000;
    localparam logic [31:0] ALL_M = 32'h1FFFFFFF;

    function automatic logic [31:0] slotw(logic [28:0] id, logic ide, logic rtr, logic en);
        return {ide, rtr, en, id};
    endfunction

    // reference model written from the requirements
    function automatic exp_t model(logic [28:0] id, logic ide, logic rtr, string tag);
        exp_t e;
        e.hit = 1'b0; e.idx = '0; e.ide = ide; e.tag = tag;
        for (int n = 0; n < 32; n++) begin
            logic [31:0] m, s;
            logic ok;
            s = sh_slot[n];
            if (mask_indiv)                                  m = sh_im[n];
            else if (queue_en && n < (int'(queue_size) + 1) * 8) m = sh_q;
            else if (n == 14)                                m = sh_a;
            else if (n == 15)                                m = sh_b;
            else                                             m = sh_g;
            ok = s[29];
            if (((s[28:0] ^ id) & m[28:0]) != 0) ok = 1'b0;
            if (ext_acc_en) begin
                if (m[31] && s[31] != ide) ok = 1'b0;
            end else if (s[31] != ide) ok = 1'b0;
            if (m[30] && s[30] != rtr) ok = 1'b0;
            if (ok && !e.hit) begin
                e.hit = 1'b1;
                e.idx = 5'(n);
            end
        end
        return e;
    endfunction

    task automatic shadow_wr(logic [6:0] a, logic [31:0] d);
        if (a < 32)       sh_slot[a] = d;
        else if (a < 64)  sh_im[a - 32] = d;
        else if (a == 64) sh_g = d;
        else if (a == 65) sh_a = d;
        else if (a == 66) sh_b = d;
        else if (a == 67) sh_q = d;
    endtask

    task automatic step();
        @(posedge clk); #1;
        frm_valid = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        step();
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        shadow_wr(a, d);
    endtask

    task automatic send(logic [28:0] id, logic ide, logic rtr, string tag);
        step();
        sbq.push_back(model(id, ide, rtr, tag));
        frm_valid = 1'b1; frm_id = id; frm_ide = ide; frm_rtr = rtr;
    endtask

    // R9: write and frame in the same cycle; frame is judged on old contents
    task automatic wr_send(logic [6:0] a, logic [31:0] d, logic [28:0] id, string tag);
        step();
        sbq.push_back(model(id, 1'b0, 1'b0, tag));
        frm_valid = 1'b1; frm_id = id; frm_ide = 1'b0; frm_rtr = 1'b0;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        shadow_wr(a, d);
    endtask

    task automatic modes(logic ind, logic qe, logic ea, logic [1:0] qs);
        step();
        mask_indiv = ind; queue_en = qe; ext_acc_en = ea; queue_size = qs;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_valid) begin
                checks++;
                if (sbq.size() == 0) begin
                    fails++;
                    $display("FAIL R8: result with nothing pending, hit=%0d idx=%0d expected none",
                             hit, hit_idx);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    if (hit !== e.hit || hit_idx !== e.idx || res_ide !== e.ide) begin
                        fails++;
                        $display("FAIL %s: hit=%0d idx=%0d ide=%0d expected hit=%0d idx=%0d ide=%0d",
                                 e.tag, hit, hit_idx, res_ide, e.hit, e.idx, e.ide);
                    end
                end
            end else if (hit !== 1'b0 || hit_idx !== 5'd0) begin
                checks++;
                fails++;
                $display("FAIL R8: idle outputs hit=%0d idx=%0d expected 0 0", hit, hit_idx);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            sh_slot[i] = '0;
            sh_im[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || hit !== 1'b0 || hit_idx !== 5'd0 || res_ide !== 1'b0) begin
            fails++;
            $display("FAIL R10: reset outputs v=%0d h=%0d i=%0d expected 0 0 0",
                     res_valid, hit, hit_idx);
        end

        modes(1'b1, 1'b0, 1'b0, 2'd0);
        send(ID_A, 1'b0, 1'b0, "R10");

        // R1 per-bit masking, standard id alignment
        wr(7'd3, slotw(ID_A, 1'b0, 1'b0, 1'b1));
        wr(7'd35, STD_M);
        send(ID_A, 1'b0, 1'b0, "R1");
        send(ID_A | 29'h5, 1'b0, 1'b0, "R1");
        send(ID_C, 1'b0, 1'b0, "R1");

        // R7 enable and lowest-index priority
        wr(7'd5, slotw(ID_C, 1'b0, 1'b0, 1'b1));
        send(ID_C, 1'b0, 1'b0, "R7");
        send(ID_A, 1'b0, 1'b0, "R7");
        wr(7'd3, slotw(ID_A, 1'b0, 1'b0, 1'b0));
        send(ID_A, 1'b0, 1'b0, "R7");

        // R5 IDE handling
        send(ID_A, 1'b1, 1'b0, "R5");
        modes(1'b1, 1'b0, 1'b1, 2'd0);
        send(ID_A, 1'b1, 1'b0, "R5");
        wr(7'd37, 32'h8000_0000);
        send(ID_A, 1'b1, 1'b0, "R5");
        send(ID_A, 1'b0, 1'b0, "R5");
        wr(7'd5, 32'h0);
        modes(1'b1, 1'b0, 1'b0, 2'd0);

        // R6 remote flag
        wr(7'd7, slotw(ID_X, 1'b1, 1'b0, 1'b1));
        wr(7'd39, 32'hFFFF_FFFF);
        send(ID_X, 1'b1, 1'b0, "R6");
        send(ID_X, 1'b1, 1'b1, "R6");
        wr(7'd39, 32'hBFFF_FFFF);
        send(ID_X, 1'b1, 1'b1, "R6");
        wr(7'd7, 32'h0);

        // R2 individual masks apply to slots 14/15 too
        wr(7'd2,  slotw(ID_A, 1'b0, 1'b0, 1'b1));
        wr(7'd14, slotw(ID_A, 1'b0, 1'b0, 1'b1));
        wr(7'd15, slotw(ID_A, 1'b0, 1'b0, 1'b1));
        wr(7'd34, ALL_M);
        wr(7'd64, ALL_M);
        wr(7'd65, ALL_M);
        send(ID_B, 1'b0, 1'b0, "R2");

        // R3 shared mask with dedicated 14/15
        modes(1'b0, 1'b0, 1'b0, 2'd0);
        send(ID_B, 1'b0, 1'b0, "R3");
        wr(7'd64, 32'h0);
        send(ID_B, 1'b0, 1'b0, "R3");
        wr(7'd64, ALL_M);
        wr(7'd65, 32'h0);
        send(ID_B, 1'b0, 1'b0, "R3");
        send(ID_A, 1'b0, 1'b0, "R3");

        // R4 queue mask and slot 14/15 occupancy
        wr(7'd65, ALL_M);
        modes(1'b0, 1'b1, 1'b0, 2'd0);
        send(ID_B, 1'b0, 1'b0, "R4");
        wr(7'd2, 32'h0);
        send(ID_B, 1'b0, 1'b0, "R4");
        modes(1'b0, 1'b1, 1'b0, 2'd1);
        send(ID_B, 1'b0, 1'b0, "R4");
        wr(7'd67, ALL_M);
        send(ID_B, 1'b0, 1'b0, "R4");

        // R9 write timing
        wr_send(7'd67, 32'h0, ID_B, "R9");
        send(ID_B, 1'b0, 1'b0, "R9");
        step();
        repeat (4) @(posedge clk);
        @(negedge clk);
        checks++;
        if (sbq.size() != 0) begin
            fails++;
            $display("FAIL R8: %0d results missing, expected 0", sbq.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule